// File: doc/BRIEF.md
# Dual-Mode Four-Channel Host Bus Front End

This block sits between an external host bus and four identical serial-channel register banks. One static pin picks the bus style. With the pin high, the host uses separate active-low read and write strobes and one active-low select per channel. With the pin low, the host uses a single active-low device select and one read/write level. In this mode two of the former select pins carry the channel number. Each access is decoded into a one-hot channel select and a 3-bit register address. The block drives the 8-bit bidirectional data bus during reads.

All host pins are asynchronous to the system clock. The block reduces them to two "access active" levels, one for reads and one for writes, and passes each level through a flop synchronizer. An edge detector then turns each access into exactly one internal read or write event. The channel register banks are modelled as eight 8-bit registers each. Register 4, bit 3 of each bank gates that channel's interrupt pin in strobe mode. The block also reshapes the interrupt pins to suit the chosen bus style, and it merges the per-channel active-low ready flags onto two shared pins.

Top module: `qbus_host_if`

## Requirements
- R1: With `mode_strobe`=1 and exactly one bit of `cs_n` low, a write access (`wr_n` low, then high) stores `data_io` into register `addr` of the channel whose `cs_n` bit is low (bit 0 = channel A ... bit 3 = channel D). The store is taken from the values held while the strobe was low, at the strobe's rising edge. A later read of the same register returns that byte.
- R2: With `mode_strobe`=1, a read access (`rd_n` low) drives the selected register onto `data_io` with `data_oe`=1 while the strobe stays low. It releases the bus (`data_oe`=0) after the strobe rises.
- R3: With `mode_strobe`=1 and two or more `cs_n` bits low, no register is written and `data_oe` stays 0.
- R4: With `mode_strobe`=0, `cs_n[0]` is the active-low device select and `wr_n` is a level: 1 means read, 0 means write. The channel is picked by {`cs_n[2]`,`cs_n[1]`}: 00 picks A, 01 picks B, 10 picks C, 11 picks D.
- R5: With `mode_strobe`=0, `rd_n` and `cs_n[3]` have no effect. Holding `rd_n` low with `cs_n[0]` high drives nothing, and an access gives the same result whatever `cs_n[3]` is.
- R6: Each channel holds eight independent 8-bit registers selected by `addr[2:0]`, all reset to 0. A write to one channel or register leaves the others unchanged.
- R7: With `mode_strobe`=1, `irq_out[i]` follows `ch_irq[i]`, and `irq_oe[i]` equals bit 3 of register 4 of channel i. That bit is 0 after reset, so every interrupt pin is high-impedance.
- R8: With `mode_strobe`=0, `irq_out` is all 0 and `irq_oe[3:1]` is 3'b111, so pins 1 to 3 are held at logic 0. `irq_oe[0]` is 1 (pin 0 pulled low, open-drain) exactly when any `ch_irq` bit is 1.
- R9: `txrdy_n` is 0 exactly when at least one `ch_txrdy_n` bit is 0, and `rxrdy_n` is 0 exactly when at least one `ch_rxrdy_n` bit is 0.
- R10: Each access produces exactly one internal read or write event, never on two consecutive cycles. Read data is on the bus by the fourth clock after the strobe falls. A write is visible by the fourth clock after the strobe rises, and the bus is released by the fourth clock after a read strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_strobe | input | 1 | Bus style: 1 = strobe style, 0 = read/write-level style |
| addr | input | 3 | Register address within the channel |
| data_io | inout | 8 | Bidirectional host data bus |
| rd_n | input | 1 | Active-low read strobe (strobe style only) |
| wr_n | input | 1 | Active-low write strobe, or read/write level |
| cs_n | input | 4 | Per-channel selects, or device select plus channel bits |
| ch_irq | input | 4 | Per-channel interrupt pending, active high |
| ch_txrdy_n | input | 4 | Per-channel transmit ready, active low |
| ch_rxrdy_n | input | 4 | Per-channel receive ready, active low |
| irq_out | output | 4 | Interrupt pin output values |
| irq_oe | output | 4 | Interrupt pin output enables |
| txrdy_n | output | 1 | Merged transmit ready, active low |
| rxrdy_n | output | 1 | Merged receive ready, active low |
| data_oe | output | 1 | High while the block drives `data_io` |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and the four-channel, eight-register, 8-bit package constants. With two stages, the whole latency of an access fits inside the four-clock windows of R10. This lets the bench place every sample at a fixed clock count after a strobe edge. Because all four channels and all eight register addresses are present, every {`cs_n[2]`,`cs_n[1]`} code and several register offsets can be written in one bus style and read back in the other.

// File: rtl/qbus_pkg.sv
// Shared constants and types for the dual-mode host bus front end.
// Assumes four channels, each with eight byte-wide registers.
package qbus_pkg;
    localparam int NUM_CH      = 4;
    localparam int REG_AW      = 3;
    localparam int DW          = 8;
    localparam int NUM_REGS    = 1 << REG_AW;
    localparam int IRQ_REG_IDX = 4;   // register holding the interrupt-pin enable
    localparam int IRQ_EN_BIT  = 3;   // bit within that register

    // Access context captured while the host holds an access active
    typedef struct packed {
        logic [NUM_CH-1:0] sel;
        logic [REG_AW-1:0] radr;
        logic [DW-1:0]     wdata;
    } qbus_cap_t;
endpackage

// File: rtl/qbus_sync.sv
// Multi-stage flop synchronizer for asynchronous level inputs.
// Assumes the inputs are levels that are stable for several clocks.
module qbus_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one synchronizer stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[s] <= '0;
                end else if (s == 0) begin
                    stg[s] <= async_i;
                end else begin
                    stg[s] <= stg[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/qbus_decode.sv
// Combinational decode of the raw host pins into access levels and a
// one-hot channel select. Assumes mode_strobe is static during use.
module qbus_decode
    import qbus_pkg::*;
(
    input  logic              mode_strobe,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [NUM_CH-1:0] cs_n,
    output logic              rd_act,
    output logic              wr_act,
    output logic [NUM_CH-1:0] sel
);
    logic [NUM_CH-1:0] cs_low;
    logic [1:0]        rw_chan;

    assign cs_low  = ~cs_n;
    assign rw_chan = {cs_n[2], cs_n[1]};

    // Build the access levels and channel select for the chosen bus style
    always_comb begin
        sel = '0;
        if (mode_strobe) begin
            rd_act = ~rd_n;
            wr_act = ~wr_n;
            if ($countones(cs_low) == 1) begin
                sel = cs_low;
            end
        end else begin
            rd_act = cs_low[0] & wr_n;
            wr_act = cs_low[0] & ~wr_n;
            if (cs_low[0]) begin
                sel[rw_chan] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/qbus_regbank.sv
// Stand-in register bank for one serial channel: eight byte registers.
// Exposes the interrupt-pin enable bit. Assumes one write per event.
module qbus_regbank
    import qbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] radr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq_pin_en
);
    logic [DW-1:0] regs [NUM_REGS];

    // Store the write byte into the addressed register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                regs[r] <= '0;
            end
        end else if (wr_en) begin
            regs[radr] <= wdata;
        end
    end

    assign rdata      = regs[radr];
    assign irq_pin_en = regs[IRQ_REG_IDX][IRQ_EN_BIT];
endmodule

// File: rtl/qbus_status_merge.sv
// Shapes interrupt pins for the bus style and merges the ready flags.
// Assumes all channel status inputs are already in the clock domain.
module qbus_status_merge
    import qbus_pkg::*;
(
    input  logic              mode_strobe,
    input  logic [NUM_CH-1:0] ch_irq,
    input  logic [NUM_CH-1:0] irq_en,
    input  logic [NUM_CH-1:0] ch_txrdy_n,
    input  logic [NUM_CH-1:0] ch_rxrdy_n,
    output logic [NUM_CH-1:0] irq_out,
    output logic [NUM_CH-1:0] irq_oe,
    output logic              txrdy_n,
    output logic              rxrdy_n
);
    // Select per-channel or shared open-drain interrupt signalling
    always_comb begin
        if (mode_strobe) begin
            irq_out = ch_irq;
            irq_oe  = irq_en;
        end else begin
            irq_out = '0;
            irq_oe  = {{(NUM_CH-1){1'b1}}, |ch_irq};
        end
    end

    assign txrdy_n = &ch_txrdy_n;
    assign rxrdy_n = &ch_rxrdy_n;
endmodule

// File: rtl/qbus_host_if.sv
// Dual-mode host bus front end for four channel register banks.
// Synchronizes the decoded access levels, makes one event per access,
// and drives the data bus during reads. Assumes the host holds address,
// select and data stable while an access is active.
module qbus_host_if
    import qbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_strobe,
    input  logic [REG_AW-1:0] addr,
    inout  wire  [DW-1:0]     data_io,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [NUM_CH-1:0] cs_n,
    input  logic [NUM_CH-1:0] ch_irq,
    input  logic [NUM_CH-1:0] ch_txrdy_n,
    input  logic [NUM_CH-1:0] ch_rxrdy_n,
    output logic [NUM_CH-1:0] irq_out,
    output logic [NUM_CH-1:0] irq_oe,
    output logic              txrdy_n,
    output logic              rxrdy_n,
    output logic              data_oe
);
    logic              rd_act_raw, wr_act_raw;
    logic [NUM_CH-1:0] sel_raw;
    logic [1:0]        act_sync;
    logic [1:0]        act_prev;
    logic              rd_pulse, wr_pulse;
    qbus_cap_t         cap_q;
    logic [DW-1:0]     rdata_q;
    logic [DW-1:0]     rd_mux;
    logic [DW-1:0]     bank_rdata [NUM_CH];
    logic [NUM_CH-1:0] irq_en;

    qbus_decode u_decode (
        .mode_strobe (mode_strobe),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .cs_n        (cs_n),
        .rd_act      (rd_act_raw),
        .wr_act      (wr_act_raw),
        .sel         (sel_raw)
    );

    qbus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({wr_act_raw, rd_act_raw}),
        .sync_o  (act_sync)
    );

    // Remember the last synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_prev <= '0;
        end else begin
            act_prev <= act_sync;
        end
    end

    assign rd_pulse = act_sync[0] & ~act_prev[0];
    assign wr_pulse = ~act_sync[1] & act_prev[1];

    // Hold the access context while the raw access is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (rd_act_raw || wr_act_raw) begin
            cap_q.sel   <= sel_raw;
            cap_q.radr  <= addr;
            cap_q.wdata <= data_io;
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
            qbus_regbank u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (wr_pulse & cap_q.sel[c]),
                .radr       (cap_q.radr),
                .wdata      (cap_q.wdata),
                .rdata      (bank_rdata[c]),
                .irq_pin_en (irq_en[c])
            );
        end
    endgenerate

    // OR together the read data of the selected bank
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (cap_q.sel[c]) begin
                rd_mux = rd_mux | bank_rdata[c];
            end
        end
    end

    // Load read data on the read event and hold the bus while active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            data_oe <= 1'b0;
        end else if (rd_pulse && (cap_q.sel != '0)) begin
            rdata_q <= rd_mux;
            data_oe <= 1'b1;
        end else if (!act_sync[0]) begin
            data_oe <= 1'b0;
        end
    end

    assign data_io = data_oe ? rdata_q : 'z;

    qbus_status_merge u_merge (
        .mode_strobe (mode_strobe),
        .ch_irq      (ch_irq),
        .irq_en      (irq_en),
        .ch_txrdy_n  (ch_txrdy_n),
        .ch_rxrdy_n  (ch_rxrdy_n),
        .irq_out     (irq_out),
        .irq_oe      (irq_oe),
        .txrdy_n     (txrdy_n),
        .rxrdy_n     (rxrdy_n)
    );
endmodule

// File: rtl/qbus_host_if_chk.sv
// Property checker for the host bus front end, attached by bind.
module qbus_host_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_strobe,
    input logic [3:0] ch_irq,
    input logic [3:0] ch_txrdy_n,
    input logic [3:0] ch_rxrdy_n,
    input logic [3:0] irq_out,
    input logic [3:0] irq_oe,
    input logic       txrdy_n,
    input logic       rxrdy_n,
    input logic       data_oe,
    input logic       rd_pulse,
    input logic       wr_pulse
);
    // R10
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R10
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse);

    // R2
    oe_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe) |-> $past(rd_pulse));

    // R8
    irq_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_strobe |-> (irq_out == 4'b0000) && (irq_oe[3:1] == 3'b111)
                         && (irq_oe[0] == ($countones(ch_irq) != 0)));

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_strobe |-> (irq_out == ch_irq));

    // R9
    ready_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!txrdy_n) == ($countones(~ch_txrdy_n) != 0))
        && ((!rxrdy_n) == ($countones(~ch_rxrdy_n) != 0)));
endmodule

bind qbus_host_if qbus_host_if_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_strobe (mode_strobe),
    .ch_irq      (ch_irq),
    .ch_txrdy_n  (ch_txrdy_n),
    .ch_rxrdy_n  (ch_rxrdy_n),
    .irq_out     (irq_out),
    .irq_oe      (irq_oe),
    .txrdy_n     (txrdy_n),
    .rxrdy_n     (rxrdy_n),
    .data_oe     (data_oe),
    .rd_pulse    (rd_pulse),
    .wr_pulse    (wr_pulse)
);

// File: tb/qbus_host_if_tb.sv
module qbus_host_if_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_strobe = 1'b1;
    logic [2:0] addr = '0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [3:0] cs_n = 4'hF;
    logic [3:0] ch_irq = '0;
    logic [3:0] ch_txrdy_n = 4'hF;
    logic [3:0] ch_rxrdy_n = 4'hF;
    logic [3:0] irq_out, irq_oe;
    logic       txrdy_n, rxrdy_n, data_oe;
    logic       tb_drv = 1'b0;
    logic [7:0] tb_dat = '0;
    wire  [7:0] data_bus;
    int         n_tests = 0;
    int         n_fail = 0;
    logic       done = 1'b0;

    assign data_bus = tb_drv ? tb_dat : 8'hzz;

    always #2.5 clk = ~clk;

    qbus_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .mode_strobe(mode_strobe), .addr(addr),
        .data_io(data_bus), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n),
        .ch_irq(ch_irq), .ch_txrdy_n(ch_txrdy_n), .ch_rxrdy_n(ch_rxrdy_n),
        .irq_out(irq_out), .irq_oe(irq_oe), .txrdy_n(txrdy_n),
        .rxrdy_n(rxrdy_n), .data_oe(data_oe)
    );

    // {mode, channel, register, data}
    localparam logic [13:0] VEC [8] = '{
        {1'b1, 2'd0, 3'd0, 8'h5A}, {1'b1, 2'd1, 3'd7, 8'hA5},
        {1'b1, 2'd2, 3'd3, 8'h3C}, {1'b1, 2'd3, 3'd1, 8'hFF},
        {1'b0, 2'd0, 3'd5, 8'h81}, {1'b0, 2'd1, 3'd2, 8'h42},
        {1'b0, 2'd2, 3'd6, 8'h18}, {1'b0, 2'd3, 3'd0, 8'hE7}
    };

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic s_write(input logic [3:0] csv, input logic [2:0] ra,
                           input logic [7:0] d);
        @(negedge clk);
        cs_n = csv; addr = ra; tb_dat = d; tb_drv = 1'b1; wr_n = 1'b0;
        cycles(4);
        wr_n = 1'b1;
        cycles(1);
        cs_n = 4'hF; tb_drv = 1'b0;
        cycles(4);
    endtask

    task automatic s_read(input logic [3:0] csv, input logic [2:0] ra,
                          output logic [7:0] d, output logic oe_on,
                          output logic oe_off);
        @(negedge clk);
        cs_n = csv; addr = ra; rd_n = 1'b0;
        cycles(4);
        d = data_bus; oe_on = data_oe;
        rd_n = 1'b1; cs_n = 4'hF;
        cycles(4);
        oe_off = data_oe;
    endtask

    task automatic r_write(input logic [1:0] ch, input logic csd,
                           input logic [2:0] ra, input logic [7:0] d);
        @(negedge clk);
        cs_n = {csd, ch[1], ch[0], 1'b0}; addr = ra; wr_n = 1'b0;
        tb_dat = d; tb_drv = 1'b1;
        cycles(4);
        cs_n[0] = 1'b1;
        cycles(1);
        wr_n = 1'b1; tb_drv = 1'b0; cs_n = 4'hF;
        cycles(4);
    endtask

    task automatic r_read(input logic [1:0] ch, input logic csd,
                          input logic [2:0] ra, output logic [7:0] d,
                          output logic oe_on);
        @(negedge clk);
        wr_n = 1'b1; cs_n = {csd, ch[1], ch[0], 1'b0}; addr = ra;
        cycles(4);
        d = data_bus; oe_on = data_oe;
        cs_n = 4'hF;
        cycles(4);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       on, off;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);

        // Reset state
        check(data_oe == 1'b0, "R2 reset bus released", data_oe, 0);
        check(irq_oe == 4'b0000, "R7 reset irq pins hi-z", irq_oe, 0);
        s_read(4'b1011, 3'd4, d, on, off);
        check(on && d == 8'h00, "R6 reset register value", d, 0);

        // Vector table: write in given style, read back in the other
        for (int v = 0; v < 8; v++) begin
            mode_strobe = VEC[v][13];
            if (VEC[v][13]) s_write(~(4'b1 << VEC[v][12:11]), VEC[v][10:8], VEC[v][7:0]);
            else            r_write(VEC[v][12:11], 1'b1, VEC[v][10:8], VEC[v][7:0]);
        end
        for (int v = 0; v < 8; v++) begin
            mode_strobe = ~VEC[v][13];
            if (!VEC[v][13]) begin
                s_read(~(4'b1 << VEC[v][12:11]), VEC[v][10:8], d, on, off);
                check(on, "R10 read drives by fourth clock", on, 1);
                check(!off, "R2 bus released after strobe", off, 0);
            end else begin
                r_read(VEC[v][12:11], 1'b1, VEC[v][10:8], d, on);
            end
            check(d == VEC[v][7:0], VEC[v][13] ? "R1 strobe write readback"
                                               : "R4 rw channel map readback",
                  d, VEC[v][7:0]);
        end

        // R6: neighbouring register of channel A untouched
        mode_strobe = 1'b1;
        s_read(4'b1110, 3'd1, d, on, off);
        check(d == 8'h00, "R6 neighbour unchanged", d, 0);

        // R3: two selects low on write and read
        s_write(4'b1100, 3'd6, 8'h77);
        s_read(4'b1110, 3'd6, d, on, off);
        check(d == 8'h00, "R3 no write to A", d, 0);
        s_read(4'b1101, 3'd6, d, on, off);
        check(d == 8'h00, "R3 no write to B", d, 0);
        s_read(4'b0110, 3'd0, d, on, off);
        check(!on, "R3 bus stays released", on, 0);

        // R5: rd_n ignored in rw mode; cs_n[3] ignored
        mode_strobe = 1'b0;
        @(negedge clk); rd_n = 1'b0; addr = 3'd0;
        cycles(6);
        check(!data_oe, "R5 rd_n ignored", data_oe, 0);
        rd_n = 1'b1;
        r_write(2'd1, 1'b0, 3'd3, 8'h99);
        r_read(2'd1, 1'b1, 3'd3, d, on);
        check(d == 8'h99, "R5 cs_n[3] ignored", d, 8'h99);

        // R7: interrupt enable bit in register 4 of channel B
        mode_strobe = 1'b1;
        s_write(4'b1101, 3'd4, 8'h08);
        ch_irq = 4'b0010;
        #1;
        check(irq_oe == 4'b0010, "R7 enable bit drives pin", irq_oe, 4'b0010);
        check(irq_out == 4'b0010, "R7 pin follows irq", irq_out, 4'b0010);
        s_write(4'b1101, 3'd4, 8'hF7);
        check(irq_oe == 4'b0000, "R7 enable cleared", irq_oe, 0);

        // R8: shared open-drain interrupt
        mode_strobe = 1'b0; ch_irq = 4'b0000;
        #1;
        check(irq_oe == 4'b1110 && irq_out == 4'b0000, "R8 idle", irq_oe, 4'b1110);
        ch_irq = 4'b0100;
        #1;
        check(irq_oe == 4'b1111 && irq_out == 4'b0000, "R8 pending", irq_oe, 4'b1111);

        // R9: ready merge
        ch_txrdy_n = 4'b1111; ch_rxrdy_n = 4'b1011;
        #1;
        check(txrdy_n == 1'b1, "R9 tx none ready", txrdy_n, 1);
        check(rxrdy_n == 1'b0, "R9 rx one ready", rxrdy_n, 0);
        ch_txrdy_n = 4'b0111;
        #1;
        check(txrdy_n == 1'b0, "R9 tx one ready", txrdy_n, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule